// File: doc/BRIEF.md
# 64-bit Global Timer with Self-Rearming Comparator

This block is a free-running 64-bit up-counter with a 64-bit compare value, an auto-increment reload and a sticky interrupt flag. It is meant as the shared time base of a processor cluster. Software programs it through a flat 32-bit register window. The counter, the compare value and the reload amount are all visible as words in that window.

The counter advances by one on every clock while the timer is enabled. It is read as two separate 32-bit words, with no latch joining them. Software gets a coherent 64-bit value by reading the upper word, then the lower word, then the upper word again, and retries if the two upper reads differ.

A compare event occurs when the comparator is enabled and the counter has reached the compare value. An event sets a sticky status flag. When auto-increment is on, the same event adds the reload amount to the compare value, which schedules the next event one period later. The single interrupt output follows the status flag gated by the interrupt enable. It drops for one cycle when a new event lands on a flag that is already set, so an edge-sensitive receiver still sees each event.

Top module: `global_timer`

## Requirements
- R1: After reset the counter, the compare value, the reload amount, the control word and the status flag are all zero, every register reads zero and `irq` is low.
- R2: The control word is at address 0. Bit 0 enables the timer, bit 1 the comparator, bit 2 the interrupt and bit 3 auto-increment. All other bits are ignored on write and read as zero.
- R3: While control bit 0 is set, the counter increases by exactly one per clock. While it is clear, the counter holds its value.
- R4: The counter low word is at address 1 and the high word at address 2, and each is writable on its own. A carry out of the low word reaches the high word in the same increment, so a high/low/high read sequence that spans the carry sees two different upper words and its retry returns the coherent value.
- R5: The compare value is written as a low word at address 3 and a high word at address 4. With the comparator enabled and auto-increment off, an event occurs in the first cycle in which counter >= compare holds. No further event occurs while that condition stays true.
- R6: The reload amount is at address 5. With auto-increment on, each cycle in which counter >= compare holds is an event, and that event adds the reload amount to the compare value. A compare value left behind by the counter therefore steps until it passes the counter.
- R7: The status flag is bit 0 of address 6 and is sticky. Writing 1 to bit 0 clears it and writing 0 has no effect. An event in the same cycle as a clear leaves the flag set.
- R8: `irq` is high exactly when the status flag is set, control bit 2 is set and no repeat gap is in progress. With control bit 2 clear, `irq` stays low.
- R9: An event that occurs while the status flag is already set drives `irq` low for exactly the following cycle, after which it returns high.
- R10: With control bit 1 clear, no event occurs, whatever the counter and compare values are.
- R11: With only control bit 0 set, the counter runs freely and the status flag stays clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Interrupt output |

## Verification
The bench times a split read so that the lower word wraps between the first and second upper reads. A design that lost or delayed the carry would return a torn value, or would never trigger the retry. It sets a counter well beyond an auto-increment comparator and checks that the compare value catches up in steps of the reload amount. A design that stepped only once would stall below the counter, and one that jumped would overshoot. It holds the match condition true with auto-increment off and checks that a write-one clear does not trigger a second event. It also lands a repeat event on a flag that is already set and checks for the one-cycle gap in `irq`, which a plain level output would not show.

// File: rtl/global_timer.sv
module global_timer #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  localparam int CNT_W = 2 * DATA_W;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
  localparam logic [2:0] A_CTRL = 3'd0, A_CLO = 3'd1, A_CHI = 3'd2,
                         A_MLO  = 3'd3, A_MHI = 3'd4, A_INC = 3'd5, A_STAT = 3'd6;

  logic [3:0]        ctrl;
  logic [CNT_W-1:0]  cnt, cmp;
  logic [DATA_W-1:0] inc;
  logic              status, hit_q, dip_q;

  wire t_en = ctrl[0];
  wire c_en = ctrl[1];
  wire i_en = ctrl[2];
  wire a_en = ctrl[3];

  wire wr_ctrl = reg_wr && reg_addr == A_CTRL;
  wire wr_clo  = reg_wr && reg_addr == A_CLO;
  wire wr_chi  = reg_wr && reg_addr == A_CHI;
  wire wr_mlo  = reg_wr && reg_addr == A_MLO;
  wire wr_mhi  = reg_wr && reg_addr == A_MHI;
  wire wr_inc  = reg_wr && reg_addr == A_INC;
  wire wr_clr  = reg_wr && reg_addr == A_STAT && reg_wdata[0];

  wire match = c_en && (cnt >= cmp);
  wire evt   = match && (a_en || !hit_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0;
      inc  <= '0;
    end else begin
      if (wr_ctrl) ctrl <= reg_wdata[3:0];
      if (wr_inc)  inc  <= reg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt <= '0;
    else if (wr_clo) cnt[DATA_W-1:0] <= reg_wdata;
    else if (wr_chi) cnt[CNT_W-1:DATA_W] <= reg_wdata;
    else if (t_en)   cnt <= cnt + CNT_ONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)             cmp <= '0;
    else if (wr_mlo)        cmp[DATA_W-1:0] <= reg_wdata;
    else if (wr_mhi)        cmp[CNT_W-1:DATA_W] <= reg_wdata;
    else if (evt && a_en)   cmp <= cmp + {{DATA_W{1'b0}}, inc};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status <= 1'b0;
      hit_q  <= 1'b0;
      dip_q  <= 1'b0;
    end else begin
      if (evt)         status <= 1'b1;
      else if (wr_clr) status <= 1'b0;
      hit_q <= match;
      dip_q <= evt && status;
    end
  end

  assign irq = i_en && status && !dip_q;

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = {{(DATA_W-4){1'b0}}, ctrl};
      A_CLO:   reg_rdata = cnt[DATA_W-1:0];
      A_CHI:   reg_rdata = cnt[CNT_W-1:DATA_W];
      A_MLO:   reg_rdata = cmp[DATA_W-1:0];
      A_MHI:   reg_rdata = cmp[CNT_W-1:DATA_W];
      A_INC:   reg_rdata = inc;
      A_STAT:  reg_rdata = {{(DATA_W-1){1'b0}}, status};
      default: reg_rdata = '0;
    endcase
  end

  a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (t_en && !wr_clo && !wr_chi) |=> cnt == $past(cnt) + CNT_ONE);

  a_r3_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!t_en && !wr_clo && !wr_chi) |=> $stable(cnt));

  a_r4_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (t_en && !wr_clo && !wr_chi && &cnt[DATA_W-1:0])
    |=> cnt[CNT_W-1:DATA_W] != $past(cnt[CNT_W-1:DATA_W]) && cnt[DATA_W-1:0] == '0);

  a_r5_event_sets: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> status);

  a_r6_reload_add: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && a_en && !wr_mlo && !wr_mhi) |=> cmp == $past(cmp) + {{DATA_W{1'b0}}, $past(inc)});

  a_r7_w1c: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && !evt) |=> !status);

  a_r8_masked: assert property (@(posedge clk) disable iff (!rst_n)
    !i_en |-> !irq);

  a_r9_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && status) |=> !irq);

  a_r10_no_cmp: assert property (@(posedge clk) disable iff (!rst_n)
    (!c_en && !status) |=> !status);
endmodule

// File: tb/global_timer_test.sv
module global_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  global_timer #(.DATA_W(32)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  localparam logic [2:0] CTRL = 0, CLO = 1, CHI = 2, MLO = 3, MHI = 4, INC = 5, STAT = 6;
  localparam int NV = 21;
  // {read, addr, data, expected}
  localparam logic [67:0] VEC [0:NV-1] = '{
    {1'b0, MHI,  32'h0000_0001, 32'h0},
    {1'b1, MHI,  32'h0,         32'h0000_0001},
    {1'b0, MLO,  32'hDEAD_BEEF, 32'h0},
    {1'b1, MLO,  32'h0,         32'hDEAD_BEEF},
    {1'b0, INC,  32'h0000_0100, 32'h0},
    {1'b1, INC,  32'h0,         32'h0000_0100},
    {1'b0, CTRL, 32'hFFFF_FFF6, 32'h0},
    {1'b1, CTRL, 32'h0,         32'h0000_0006},
    {1'b1, STAT, 32'h0,         32'h0},
    {1'b0, CHI,  32'h1234_5678, 32'h0},
    {1'b1, CHI,  32'h0,         32'h1234_5678},
    {1'b0, CLO,  32'h9ABC_DEF0, 32'h0},
    {1'b1, CLO,  32'h0,         32'h9ABC_DEF0},
    {1'b1, STAT, 32'h0,         32'h0000_0001},
    {1'b0, STAT, 32'h0,         32'h0},
    {1'b1, STAT, 32'h0,         32'h0000_0001},
    {1'b0, STAT, 32'h0000_0001, 32'h0},
    {1'b1, STAT, 32'h0,         32'h0},
    {1'b1, CHI,  32'h0,         32'h1234_5678},
    {1'b0, CTRL, 32'h0,         32'h0},
    {1'b1, CTRL, 32'h0,         32'h0}
  };

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    logic [31:0] d, a0, b0, h1, lo, h2;
    logic [63:0] first_try;
    int retries;
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int r = 0; r < 7; r++) begin
      rd(3'(r), d);
      check($sformatf("R1 reg %0d after reset", r), d, 0);
    end
    check("R1 irq after reset", irq, 0);

    // Table walk: R2 control masking, R5 single event, R7 write-one-clear
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][67]) begin
        rd(VEC[i][66:64], d);
        check($sformatf("R2/R5/R7 table step %0d", i), d, VEC[i][31:0]);
      end else begin
        wr(VEC[i][66:64], VEC[i][63:32]);
      end
    end

    // R6 auto-increment step and catch-up
    wr(CLO, 0); wr(CHI, 0); wr(MHI, 0); wr(MLO, 10); wr(INC, 5);
    wr(CTRL, 32'h0A);
    rd(STAT, d);
    check("R6 no event below compare", d, 0);
    wr(CLO, 12);
    idle(1);
    rd(MLO, d);
    check("R6 compare advanced by reload", d, 15);
    rd(MLO, d);
    check("R6 compare stable once above counter", d, 15);
    wr(CLO, 30);
    idle(5);
    rd(MLO, d);
    check("R6 compare caught up past counter", d, 35);
    rd(MHI, d);
    check("R6 compare high word", d, 0);
    rd(STAT, d);
    check("R6 status set by auto event", d, 1);

    // R8 masking and enabling
    check("R8 irq masked with enable clear", irq, 0);
    wr(CTRL, 32'h0E);
    #1 check("R8 irq follows status and enable", irq, 1);

    // R9 repeat event on a set flag
    wr(CLO, 36);
    #1 check("R9 irq before repeat gap", irq, 1);
    @(negedge clk);
    #1 check("R9 irq low in repeat gap", irq, 0);
    @(negedge clk);
    #1 check("R9 irq back high after gap", irq, 1);
    @(negedge clk);
    rd(MLO, d);
    check("R9 compare after repeat event", d, 40);

    // R7 clear drops irq
    wr(STAT, 1);
    #1 check("R7 irq after clear", irq, 0);
    @(negedge clk);
    rd(STAT, d);
    check("R7 status after clear", d, 0);

    // R10 comparator disabled
    wr(CTRL, 32'h05);
    wr(CLO, 100);
    idle(4);
    rd(STAT, d);
    check("R10 no event with comparator off", d, 0);
    check("R10 irq stays low", irq, 0);

    // R3 / R11 free running count and hold
    wr(CTRL, 0); wr(CLO, 0); wr(CHI, 0);
    wr(CTRL, 1);
    rd(CLO, a0);
    idle(9);
    rd(CLO, b0);
    check("R3 ten increments in ten cycles", b0 - a0, 10);
    rd(STAT, d);
    check("R11 free run leaves status clear", d, 0);
    wr(CTRL, 0);
    rd(CLO, a0);
    idle(4);
    rd(CLO, b0);
    check("R3 counter holds when disabled", b0, a0);

    // R4 split read across a carry
    wr(CHI, 7); wr(CLO, 32'hFFFF_FFFE);
    wr(CTRL, 1);
    retries = 0;
    first_try = '0;
    forever begin
      rd(CHI, h1);
      rd(CLO, lo);
      rd(CHI, h2);
      if (retries == 0) first_try = {h1, lo};
      if (h1 == h2) break;
      retries++;
    end
    check("R4 retry triggered by carry", retries, 1);
    check("R4 torn first attempt", first_try, 64'h0000_0007_FFFF_FFFF);
    check("R4 coherent value after retry", {h2, lo}, 64'h0000_0008_0000_0002);

    // R1 reset while running
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    rd(CHI, d);
    check("R1 counter high after second reset", d, 0);
    rd(CTRL, d);
    check("R1 control after second reset", d, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule